// File: doc/BRIEF.md
# Reloadable Synchronized Timebase Counter

Each node of a sensor network carries this block to hold a time base that is shared across the network. A down counter divides the system clock. Each time the counter passes through zero, the block emits one sync event and the counter restarts from a programmable period value. Every sync event advances a time-stamp counter, and the node uses that count to label the data it acquires.

To bring the divider into phase with the reference node, the message layer presents a received down-counter value together with a load strobe. The block writes that value straight into its own counter. Before doing so it subtracts a compensation offset, which covers the fixed number of cycles the value spent in transit.

The counter value can go below zero when the offset is subtracted. In that case the result wraps into the top of the count range, and the block raises the sync event that the subtraction stepped over.

Each cycle the block takes exactly one action, chosen by a small decode:

| Action | Taken when | Next count |
|---|---|---|
| `ACT_DEC` | no load strobe and count is nonzero | count − 1 |
| `ACT_RELOAD` | no load strobe and count is zero | period |
| `ACT_LOAD` | load strobe and received value ≥ offset | received value − offset |
| `ACT_LOAD_WRAP` | load strobe and received value < offset | received value + period + 1 − offset |

`ACT_RELOAD` and `ACT_LOAD_WRAP` emit a sync event. `ACT_DEC` and `ACT_LOAD` do not.

Top module: `stb_timebase`

## Requirements
- R1: Reset sets the following outputs.
  - `div_count` equals the parameter `RST_PERIOD`.
  - `stamp` is 0.
  - `tick` is 0.
  - `sync_sq` is 0.
- R2: With `rx_load` low and `div_count` nonzero, `div_count` drops by exactly one at the next edge, and `tick` stays low.
- R3: This requirement covers the reload at zero.
  - With `rx_load` low and `div_count` zero, the next edge loads the stored period into `div_count` and drives `tick` high for one cycle.
  - With no loads, ticks therefore occur every period + 1 cycles.
  - `div_count` equals the period in each tick cycle.
- R4: `stamp` rises by one, modulo 2^TS_W, in every cycle where `tick` is high. For the default 16-bit width, 0xFFFF is followed by 0x0000. `stamp` holds its value in every other cycle.
- R5: `sync_sq` inverts in every cycle where `tick` is high and holds its value otherwise.
- R6: `rx_load` high with `rx_count` ≥ `comp_ofs` sets `div_count` to `rx_count − comp_ofs` at the next edge, with no tick.
- R7: `rx_load` high with `rx_count` < `comp_ofs` sets `div_count` to `rx_count + period + 1 − comp_ofs` at the next edge. The same edge raises `tick` and advances `stamp`.
- R8: A load strobe wins over both the reload and the decrement in the same cycle. A load in a cycle where `div_count` is zero gives the loaded value, not the period.
- R9: A write to the period (`cfg_we` high) leaves `div_count` unchanged that cycle. The new period is used from the next reload on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Period write strobe |
| cfg_period | input | CNT_W | New divider period; the event rate is f_clk / (1 + period) |
| comp_ofs | input | CNT_W | Transit-delay compensation in cycles; must not exceed the period |
| rx_load | input | 1 | Strobe: a received counter value is present |
| rx_count | input | CNT_W | Received counter value; must not exceed the period |
| tick | output | 1 | One-cycle sync event pulse |
| sync_sq | output | 1 | Square wave that toggles on each sync event |
| div_count | output | CNT_W | Current down-counter value |
| stamp | output | TS_W | Time-stamp counter |

## Verification
The divider is run with periods 0, 1, 2, 5 and 9. The measured tick spacing must equal period + 1. Period 0 separates "tick every cycle" from an off-by-one in the reload.

Every pair of received value and offset from 0 to 5 is loaded against a period of 5. This sweep separates the plain subtraction from the wrapped case, including the boundary where the value equals the offset. Each load is followed by a step that confirms normal counting resumes.

Three further cases are each tried once:
- a load applied in a zero cycle, which exposes the load/reload priority;
- a period written mid-count, which exposes early use of the new period;
- a run of the time stamp through 0xFFFF, which exposes the wrap.

// File: rtl/stb_types_pkg.sv
package stb_types_pkg;
    typedef enum logic [1:0] {
        ACT_DEC       = 2'd0,
        ACT_RELOAD    = 2'd1,
        ACT_LOAD      = 2'd2,
        ACT_LOAD_WRAP = 2'd3
    } stb_act_e;
endpackage

// File: rtl/stb_decode.sv
module stb_decode
    import stb_types_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] ofs,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output stb_act_e         act,
    output logic [CNT_W-1:0] nxt,
    output logic             evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // pick this cycle's action: load first, then zero detection
    always_comb begin
        if (load) begin
            act = (load_val < ofs) ? ACT_LOAD_WRAP : ACT_LOAD;
        end else begin
            act = (cnt == '0) ? ACT_RELOAD : ACT_DEC;
        end
    end

    // next count and event for the chosen action
    always_comb begin
        unique case (act)
            ACT_DEC: begin
                nxt = cnt - ONE;
                evt = 1'b0;
            end
            ACT_RELOAD: begin
                nxt = period;
                evt = 1'b1;
            end
            ACT_LOAD: begin
                nxt = load_val - ofs;
                evt = 1'b0;
            end
            ACT_LOAD_WRAP: begin
                // modulo (period + 1) subtraction
                nxt = load_val + period + ONE - ofs;
                evt = 1'b1;
            end
            default: begin
                nxt = cnt;
                evt = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/stb_divreg.sv
module stb_divreg #(
    parameter int               CNT_W      = 16,
    parameter logic [CNT_W-1:0] RST_PERIOD = CNT_W'(19999)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] nxt,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= RST_PERIOD;
        end else begin
            cnt <= nxt;
        end
    end
endmodule

// File: rtl/stb_stamp.sv
module stb_stamp #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            evt,
    output logic            tick,
    output logic            sq,
    output logic [TS_W-1:0] stamp
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick  <= 1'b0;
            sq    <= 1'b0;
            stamp <= '0;
        end else begin
            tick <= evt;
            if (evt) begin
                sq    <= ~sq;
                stamp <= stamp + TS_W'(1);
            end
        end
    end
endmodule

// File: rtl/stb_timebase.sv
module stb_timebase
    import stb_types_pkg::*;
#(
    parameter int               CNT_W      = 16,
    parameter int               TS_W       = 16,
    parameter logic [CNT_W-1:0] RST_PERIOD = CNT_W'(19999)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] comp_ofs,
    input  logic             rx_load,
    input  logic [CNT_W-1:0] rx_count,
    output logic             tick,
    output logic             sync_sq,
    output logic [CNT_W-1:0] div_count,
    output logic [TS_W-1:0]  stamp
);
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             evt;
    stb_act_e         act;

    // period register: used only when the counter next reloads or wraps
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= RST_PERIOD;
        end else if (cfg_we) begin
            period_q <= cfg_period;
        end
    end

    stb_decode #(.CNT_W(CNT_W)) u_dec (
        .cnt      (div_count),
        .period   (period_q),
        .ofs      (comp_ofs),
        .load     (rx_load),
        .load_val (rx_count),
        .act      (act),
        .nxt      (cnt_nxt),
        .evt      (evt)
    );

    stb_divreg #(.CNT_W(CNT_W), .RST_PERIOD(RST_PERIOD)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (cnt_nxt),
        .cnt   (div_count)
    );

    stb_stamp #(.TS_W(TS_W)) u_ts (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .tick  (tick),
        .sq    (sync_sq),
        .stamp (stamp)
    );
endmodule

// File: rtl/stb_timebase_chk.sv
module stb_timebase_chk #(
    parameter int CNT_W = 16,
    parameter int TS_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_load,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] comp_ofs,
    input logic [CNT_W-1:0] period_q,
    input logic             tick,
    input logic             sync_sq,
    input logic [CNT_W-1:0] div_count,
    input logic [TS_W-1:0]  stamp
);
    // R2
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_load && div_count != '0) |=> (div_count == CNT_W'($past(div_count) - CNT_W'(1))) && !tick);

    // R3
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_load && div_count == '0) |=> (div_count == $past(period_q)) && tick);

    // R4
    stamp_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (stamp == TS_W'($past(stamp) + TS_W'(1))));

    // R4
    stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |-> $stable(stamp));

    // R5
    sq_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (sync_sq != $past(sync_sq)));

    // R5
    sq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |-> $stable(sync_sq));

    // R6
    load_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load && rx_count >= comp_ofs) |=>
            (div_count == CNT_W'($past(rx_count) - $past(comp_ofs))) && !tick);

    // R7
    load_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load && rx_count < comp_ofs) |=>
            tick && (div_count == CNT_W'($past(rx_count) + $past(period_q) + CNT_W'(1) - $past(comp_ofs))));
endmodule

bind stb_timebase stb_timebase_chk #(.CNT_W(CNT_W), .TS_W(TS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_load   (rx_load),
    .rx_count  (rx_count),
    .comp_ofs  (comp_ofs),
    .period_q  (period_q),
    .tick      (tick),
    .sync_sq   (sync_sq),
    .div_count (div_count),
    .stamp     (stamp)
);

// File: tb/sim_stb_timebase.sv
`timescale 1ns/1ps
module sim_stb_timebase;
    localparam int CNT_W = 16;
    localparam int TS_W  = 16;
    localparam int RSTP  = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [CNT_W-1:0] cfg_period = '0;
    logic [CNT_W-1:0] comp_ofs = '0;
    logic             rx_load = 1'b0;
    logic [CNT_W-1:0] rx_count = '0;
    logic             tick;
    logic             sync_sq;
    logic [CNT_W-1:0] div_count;
    logic [TS_W-1:0]  stamp;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    stb_timebase #(.CNT_W(CNT_W), .TS_W(TS_W), .RST_PERIOD(CNT_W'(RSTP))) u0 (
        .clk, .rst_n, .cfg_we, .cfg_period, .comp_ofs, .rx_load, .rx_count,
        .tick, .sync_sq, .div_count, .stamp
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // advance one edge; outputs are sampled and inputs driven 2 ns after it
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wait_tick();
        for (int i = 0; i < 200; i++) begin
            step();
            if (tick) break;
        end
    endtask

    task automatic set_period(input int p);
        cfg_we = 1'b1;
        cfg_period = CNT_W'(p);
        step();
        cfg_we = 1'b0;
        wait_tick();
        wait_tick();
    endtask

    initial begin : main
        int s0, q0, n, expc, expn;
        int periods [5] = '{0, 1, 2, 5, 9};

        // R1 reset state
        repeat (3) @(posedge clk);
        #2;
        chk(int'(div_count) == RSTP, "R1 count", int'(div_count), RSTP);
        chk(stamp == '0, "R1 stamp", int'(stamp), 0);
        chk(tick == 1'b0, "R1 tick", int'(tick), 0);
        chk(sync_sq == 1'b0, "R1 sq", int'(sync_sq), 0);
        rst_n = 1'b1;

        // R2 decrement
        step();
        chk(int'(div_count) == RSTP - 1, "R2 dec", int'(div_count), RSTP - 1);
        step();
        chk(int'(div_count) == RSTP - 2, "R2 dec", int'(div_count), RSTP - 2);

        // R3 R4 R5 period sweep
        foreach (periods[k]) begin
            set_period(periods[k]);
            chk(int'(div_count) == periods[k], "R3 count at tick", int'(div_count), periods[k]);
            s0 = int'(stamp);
            q0 = int'(sync_sq);
            n = 0;
            for (int i = 0; i < 200; i++) begin
                step();
                n++;
                if (tick) break;
            end
            chk(n == periods[k] + 1, "R3 spacing", n, periods[k] + 1);
            chk(int'(stamp) == ((s0 + 1) & 16'hFFFF), "R4 stamp step", int'(stamp), (s0 + 1) & 16'hFFFF);
            chk(int'(sync_sq) == (q0 ^ 1), "R5 sq toggle", int'(sync_sq), q0 ^ 1);
        end

        // R9 period write mid-count (period is 9 now)
        for (int i = 0; i < 20; i++) begin
            if (int'(div_count) == 5) break;
            step();
        end
        cfg_we = 1'b1;
        cfg_period = CNT_W'(3);
        step();
        cfg_we = 1'b0;
        chk(int'(div_count) == 4, "R9 count undisturbed", int'(div_count), 4);
        wait_tick();
        chk(int'(div_count) == 3, "R9 new period at reload", int'(div_count), 3);

        // R6 R7 load sweep against period 5
        set_period(5);
        for (int v = 0; v <= 5; v++) begin
            for (int o = 0; o <= 5; o++) begin
                s0 = int'(stamp);
                rx_load = 1'b1;
                rx_count = CNT_W'(v);
                comp_ofs = CNT_W'(o);
                step();
                rx_load = 1'b0;
                expc = (v >= o) ? (v - o) : (v + 6 - o);
                if (v >= o) begin
                    chk(int'(div_count) == expc, "R6 load count", int'(div_count), expc);
                    chk(tick == 1'b0, "R6 no tick", int'(tick), 0);
                end else begin
                    chk(int'(div_count) == expc, "R7 wrap count", int'(div_count), expc);
                    chk(tick == 1'b1, "R7 tick", int'(tick), 1);
                    chk(int'(stamp) == ((s0 + 1) & 16'hFFFF), "R7 stamp", int'(stamp), (s0 + 1) & 16'hFFFF);
                end
                step();
                expn = (expc == 0) ? 5 : expc - 1;
                chk(int'(div_count) == expn, "R2 resume after load", int'(div_count), expn);
            end
        end

        // R8 load in a zero cycle
        for (int i = 0; i < 20; i++) begin
            if (div_count == '0) break;
            step();
        end
        rx_load = 1'b1;
        rx_count = CNT_W'(3);
        comp_ofs = CNT_W'(1);
        step();
        rx_load = 1'b0;
        chk(int'(div_count) == 2, "R8 load wins", int'(div_count), 2);
        chk(tick == 1'b0, "R8 no reload tick", int'(tick), 0);

        // R4 wrap with period 0
        comp_ofs = '0;
        set_period(0);
        for (int i = 0; i < 70000; i++) begin
            if (stamp == 16'hFFFF) break;
            step();
        end
        chk(stamp == 16'hFFFF, "R4 reach max", int'(stamp), 65535);
        step();
        chk(stamp == '0, "R4 wrap", int'(stamp), 0);
        chk(tick == 1'b1, "R4 wrap tick", int'(tick), 1);

        done = 1'b1;
    end

    initial begin : finish_ctl
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule